// File: doc/BRIEF.md
# Half-Rate Interleaved Shift Register

This block delays a data stream by a fixed number of clock cycles, exactly as a plain single-chain shift register of the same length would. Inside, the storage is split into several lanes. A free-running phase counter deals successive input samples to the lanes in round-robin order. In the default configuration there are two lanes, so even-numbered samples go to one chain and odd-numbered samples go to the other. Each lane shifts only on its own phase, so with two lanes every storage flop is enabled on one edge in two. In silicon, that enable becomes a half-frequency clock for the chain.

A multiplexer driven by the same phase counter merges the lane tails back into one full-rate stream. The total depth defaults to 16 samples, split as 8 stages per lane. The lane count is a parameter, and the depth must be a multiple of it. Reset clears every stage and returns the phase counter to lane 0.

Top module: `hrsr_top`

## Requirements
- R1: While reset is held, and for the first DEPTH rising edges after reset is released, `dout` is all zeros.
- R2: After those DEPTH edges, `dout` equals the `din` value that was captured DEPTH rising edges earlier, whatever the data pattern. The default latency is 16 cycles.
- R3: Samples are dealt round-robin. The sample captured at the j-th edge after reset enters lane (j-1) mod LANES, and exactly one lane captures on each edge. An isolated 1 entered at either an even or an odd position appears at `dout` exactly DEPTH cycles later, and at no other time.
- R4: Reset, including reset asserted in the middle of a stream, discards all stored samples and restarts the phase at lane 0. After release, the output is zero for DEPTH cycles and is then aligned again as in R2.
- R5: The output lane is selected on the same phase that captured the sample, so neighbouring samples are never exchanged. The alternating pattern 0,1,0,1 leaves the block in the same order it entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | WIDTH | Input sample, captured on every rising edge |
| dout | output | WIDTH | Delayed sample stream |

## Verification
Single-one impulses are placed at every offset from 0 to 3 after reset. These show whether both the even and the odd lane carry their sample with the correct latency, and whether a sample leaks into a neighbouring cycle. The alternating pattern catches a swapped output select or a swapped capture phase, which impulses alone can miss when the two lanes are symmetric. A long pseudo-random stream compares every cycle against a history indexed by edge count. Filling the chains with ones and then resetting mid-stream shows that reset clears both lanes and realigns the phase.

// File: rtl/hrsr_pkg.sv
package hrsr_pkg;

    // Width of a counter that names one of `lanes` lanes.
    function automatic int unsigned phase_bits(int unsigned lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    // Width of a saturating counter that reaches `limit`.
    function automatic int unsigned count_bits(int unsigned limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/hrsr_phase_seq.sv
module hrsr_phase_seq
    import hrsr_pkg::*;
#(
    parameter int unsigned LANES = 2,
    localparam int unsigned PW = phase_bits(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PW-1:0]    phase,
    output logic [LANES-1:0] lane_en
);

    localparam logic [PW-1:0] LAST_PHASE = PW'(LANES - 1);

    logic [PW-1:0] phase_q;

    // Phase register: steps through the lanes once per full-rate edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST_PHASE) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // One-hot decode: lane k shifts only on its own phase.
    for (genvar k = 0; k < LANES; k++) begin : g_dec
        assign lane_en[k] = (phase_q == PW'(k));
    end

    assign phase = phase_q;

endmodule

// File: rtl/hrsr_lane.sv
module hrsr_lane #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] tail
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Chain shifts only when its phase is active: a reduced-rate clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else if (en) begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign tail = stage_q[STAGES-1];

endmodule

// File: rtl/hrsr_out_mux.sv
module hrsr_out_mux #(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned LANES = 2,
    parameter int unsigned PW    = 1
) (
    input  logic [PW-1:0]                 sel,
    input  logic [LANES-1:0][WIDTH-1:0]   tails,
    output logic [WIDTH-1:0]              dout
);

    // The lane that captures on this phase is the one whose oldest
    // sample is due now; it is read before the same edge overwrites it.
    always_comb begin
        dout = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel == PW'(k)) begin
                dout = tails[k];
            end
        end
    end

endmodule

// File: rtl/hrsr_top.sv
module hrsr_top
    import hrsr_pkg::*;
#(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    localparam int unsigned STAGES = DEPTH / LANES;
    localparam int unsigned PW     = phase_bits(LANES);

    logic [PW-1:0]               phase_q;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][WIDTH-1:0] lane_tail;

    hrsr_phase_seq #(
        .LANES (LANES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase_q),
        .lane_en (lane_en)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        hrsr_lane #(
            .WIDTH  (WIDTH),
            .STAGES (STAGES)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (lane_en[k]),
            .din   (din),
            .tail  (lane_tail[k])
        );
    end

    hrsr_out_mux #(
        .WIDTH (WIDTH),
        .LANES (LANES),
        .PW    (PW)
    ) u_mux (
        .sel   (phase_q),
        .tails (lane_tail),
        .dout  (dout)
    );

endmodule

// File: rtl/hrsr_chk.sv
module hrsr_chk
    import hrsr_pkg::*;
#(
    parameter int unsigned WIDTH = 1,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 2,
    localparam int unsigned PW = phase_bits(LANES),
    localparam int unsigned CW = count_bits(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout,
    input logic [PW-1:0]    phase,
    input logic [LANES-1:0] lane_en
);

    localparam logic [PW-1:0] LAST_PHASE = PW'(LANES - 1);

    logic [CW-1:0]    fill_q;
    logic             started_q;
    logic [WIDTH-1:0] shadow_q [DEPTH];

    // Edge counter, plus a plain single-chain model of the delay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q    <= '0;
            started_q <= 1'b0;
            for (int s = 0; s < DEPTH; s++) shadow_q[s] <= '0;
        end else begin
            started_q <= 1'b1;
            if (fill_q != CW'(DEPTH)) fill_q <= fill_q + 1'b1;
            shadow_q[0] <= din;
            for (int s = 1; s < DEPTH; s++) shadow_q[s] <= shadow_q[s-1];
        end
    end

    AST_ZERO_WHILE_FILLING: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q < CW'(DEPTH)) |-> (dout == '0)); // R1

    AST_DELAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dout == shadow_q[DEPTH-1]); // R2

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_en) == 1); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (phase == (($past(phase) == LAST_PHASE) ? '0 : $past(phase) + 1'b1))); // R3

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == '0) |-> (phase == '0)); // R4

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == CW'(DEPTH)) |=> (dout == $past(shadow_q[DEPTH-2]))); // R5

endmodule

bind hrsr_top hrsr_chk #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .LANES (LANES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .dout    (dout),
    .phase   (phase_q),
    .lane_en (lane_en)
);

// File: tb/sim_hrsr_top.sv
`timescale 1ns/1ps
module sim_hrsr_top;

    localparam int DEPTH = 16;
    localparam int HIST  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;
    logic hist [HIST];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    hrsr_top #(.WIDTH(1), .DEPTH(DEPTH), .LANES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout)
    );

    task automatic check(input logic exp, input string tag);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: dout=%b expected=%b", tag, edge_n, dout, exp);
        end
    endtask

    // Check the output after the previous edge, then drive the next sample.
    task automatic step(input logic v, input string fill_tag, input string run_tag);
        logic exp;
        @(negedge clk);
        if (edge_n < DEPTH) begin
            check(1'b0, fill_tag);
        end else begin
            exp = hist[(edge_n - DEPTH + 1) % HIST];
            check(exp, run_tag);
        end
        din = v;
        hist[(edge_n + 1) % HIST] = v;
        @(posedge clk);
        edge_n++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = 1'b0;
        @(negedge clk);
        check(1'b0, "R1");
        @(negedge clk);
        check(1'b0, "R4");
        rst_n = 1'b1;
        edge_n = 0;
    endtask

    initial begin : watchdog
        #500000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        // R3: isolated ones at even and odd positions
        for (int off = 0; off < 4; off++) begin
            do_reset();
            for (int i = 0; i < off; i++) step(1'b0, "R1", "R3");
            step(1'b1, "R1", "R3");
            for (int i = 0; i < 2 * DEPTH; i++) step(1'b0, "R1", "R3");
        end

        // R5: alternating pattern keeps its order
        do_reset();
        for (int i = 0; i < 3 * DEPTH; i++) step(1'(i % 2), "R1", "R5");
        for (int i = 0; i < 3 * DEPTH; i++) step(1'((i / 3) % 2), "R1", "R5");

        // R2: pseudo-random stream
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], "R1", "R2");
        end

        // R4: fill with ones, reset mid-stream, confirm clear and realignment
        for (int i = 0; i < DEPTH + 5; i++) step(1'b1, "R1", "R2");
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1'b1, "R4", "R4");
        for (int i = 0; i < DEPTH; i++) step(1'(i % 3 == 0), "R4", "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule